// File: doc/BRIEF.md
# Latency-Aligned Word Copy Engine

The engine moves the whole contents of a 32-bit source memory into the 32-bit write port of a width-converting buffer whose other port is read one byte at a time. The source memory has a registered read, so each data word comes back one clock after its address. The engine therefore issues the read address and read strobe from a counter, and it drives the buffer write address and write strobe from a copy of those signals that is one cycle older. Each buffer location then receives the word read from the same source location. Location 0 never takes the stale word left on the source data bus, and the final word is still written after the last read.

Several source memories can share the engine, one at a time. A select index is captured when the transfer starts and is held on an output for the whole transfer, so the system can steer the shared read data from the chosen source. A start pulse while a transfer is running has no effect. The engine also provides the byte-side addressing of the buffer. A 7-bit byte address is split into a word address and a lane, and the lane picks 8 bits out of the 32-bit word that the buffer returns.

Top module: `wide_copy_engine`

## Requirements
- R1: After reset, busy, done, the source read strobe and the buffer write strobe are all low.
- R2: A start pulse taken while idle starts a read on the next cycle. The read strobe is high for exactly 32 consecutive cycles, with source addresses 0, 1, ..., 31 in that order.
- R3: The buffer write strobe and write address equal the read strobe and read address of the previous cycle. The write data is the source read data of the current cycle.
- R4: When a transfer ends, every buffer location k holds source word k of the selected source. No location keeps old contents, and location 31 is written too.
- R5: The last buffer write takes place on the 33rd clock edge after the one that samples start. Done is high for exactly one cycle after that edge, and busy falls in the same cycle.
- R6: A start pulse while busy is ignored. The address sequence, the selected source and the completion time do not change.
- R7: The source select is latched when start is accepted and stays stable for the whole transfer. Changes on the select input during the transfer have no effect.
- R8: Byte address b (7 bits) reads buffer word b[6:2], and lane b[1:0] gives bits 8*lane+7 down to 8*lane of that word. Byte 0 is bits 7:0 of word 0 (little-endian).
- R9: A start in the cycle where done is high is accepted, so transfers can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse |
| sel_in | input | 2 | Source index offered with start |
| src_sel | output | 2 | Latched source index |
| src_addr | output | 5 | Source read address |
| src_rd | output | 1 | Source read strobe |
| src_data | input | 32 | Source read data, one cycle after the address |
| buf_we | output | 1 | Buffer write strobe |
| buf_waddr | output | 5 | Buffer write address |
| buf_wdata | output | 32 | Buffer write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| byte_addr | input | 7 | Byte-side read address |
| byte_word_addr | output | 5 | Buffer word address for the byte side |
| byte_word | input | 32 | Word returned by the buffer |
| byte_data | output | 8 | Selected byte |

## Verification
On every cycle the assertions check the local timing rules: the one-cycle skew between the read and write strobes and addresses, the read address stepping by one, the read strobe appearing only while busy, the select staying stable during a transfer, and done being a single pulse that follows the write of word 31. Only the bench's scenarios can show the end results. These are the full buffer contents matching the chosen source with no stale location 0, ignored start and select changes in the middle of a transfer, back-to-back starts, and the little-endian byte order over all 128 byte addresses for every source.

// File: rtl/wide_copy_engine.sv
module wide_copy_engine #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 2,
  parameter int LANE_W = 8,
  localparam int LANES   = DATA_W / LANE_W,
  localparam int LANE_AW = $clog2(LANES),
  localparam int BYTE_AW = ADDR_W + LANE_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SEL_W-1:0]   sel_in,
  output logic [SEL_W-1:0]   src_sel,
  output logic [ADDR_W-1:0]  src_addr,
  output logic               src_rd,
  input  logic [DATA_W-1:0]  src_data,
  output logic               buf_we,
  output logic [ADDR_W-1:0]  buf_waddr,
  output logic [DATA_W-1:0]  buf_wdata,
  output logic               busy,
  output logic               done,
  input  logic [BYTE_AW-1:0] byte_addr,
  output logic [ADDR_W-1:0]  byte_word_addr,
  input  logic [DATA_W-1:0]  byte_word,
  output logic [LANE_W-1:0]  byte_data
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W:0]   cnt;
  logic [ADDR_W-1:0] wa_q;
  logic [SEL_W-1:0]  sel_q;
  logic              busy_q, we_q, done_q;

  assign src_rd    = busy_q & ~cnt[ADDR_W];
  assign src_addr  = cnt[ADDR_W-1:0];
  assign src_sel   = sel_q;
  assign buf_we    = we_q;
  assign buf_waddr = wa_q;
  assign buf_wdata = src_data;
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      wa_q   <= '0;
      sel_q  <= '0;
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (!busy_q && start) begin
        busy_q <= 1'b1;
        cnt    <= '0;
        sel_q  <= sel_in;
      end else if (src_rd) begin
        cnt <= cnt + 1'b1;
      end
      we_q   <= src_rd;
      wa_q   <= src_addr;
      done_q <= we_q && (wa_q == LAST);
      if (we_q && (wa_q == LAST)) busy_q <= 1'b0;
    end
  end

  assign byte_word_addr = byte_addr[BYTE_AW-1:LANE_AW];
  assign byte_data      = byte_word[byte_addr[LANE_AW-1:0]*LANE_W +: LANE_W];
endmodule

// File: rtl/wide_copy_engine_chk.sv
module wide_copy_engine_chk #(
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_rd,
  input logic [ADDR_W-1:0] src_addr,
  input logic [SEL_W-1:0]  src_sel,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_waddr,
  input logic              busy,
  input logic              done
);
  // R3
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |=> (buf_we && buf_waddr == $past(src_addr)));
  // R3
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(src_rd));
  // R2
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |-> busy);
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && $past(src_rd)) |-> src_addr == $past(src_addr) + 1'b1);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(buf_we) && $past(buf_waddr) == '1 && !busy));
  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(src_sel));
endmodule

bind wide_copy_engine wide_copy_engine_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_rd(src_rd), .src_addr(src_addr),
  .src_sel(src_sel), .buf_we(buf_we), .buf_waddr(buf_waddr),
  .busy(busy), .done(done)
);

// File: tb/wide_copy_engine_test.sv
module wide_copy_engine_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clr = 1'b0;
  logic [1:0] sel_in = '0, src_sel;
  logic [4:0] src_addr, buf_waddr, byte_word_addr;
  logic src_rd, buf_we, busy, done;
  logic [31:0] src_data = '0, buf_wdata, byte_word;
  logic [6:0] byte_addr = '0;
  logic [7:0] byte_data;
  logic [31:0] bufm [32];
  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  wide_copy_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_in(sel_in), .src_sel(src_sel),
    .src_addr(src_addr), .src_rd(src_rd), .src_data(src_data), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .busy(busy), .done(done),
    .byte_addr(byte_addr), .byte_word_addr(byte_word_addr), .byte_word(byte_word),
    .byte_data(byte_data)
  );

  function automatic logic [31:0] src_word(input int s, input int k);
    return {8'(s) ^ 8'h5A, 8'(k), 8'(k * 7 + s), ~8'(k)};
  endfunction

  always @(posedge clk) if (src_rd) src_data <= src_word(int'(src_sel), int'(src_addr));

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 32; i++) bufm[i] <= 32'hBAD0_0000 | 32'(i);
    end else if (buf_we) bufm[buf_waddr] <= buf_wdata;
  end
  assign byte_word = bufm[byte_word_addr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic copy(input int s, input bit chained, input bit poke,
                      input bit chain_next, input int s_next);
    if (!chained) begin
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0; start = 1'b1; sel_in = 2'(s);
    end
    for (int n = 0; n <= 33; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == 0) start = 1'b0;
      if (n <= 31) begin
        chk(n > 10 && poke ? "R6 read strobe" : "R2 read strobe", 32'(src_rd), 1);
        chk(n > 10 && poke ? "R6 read address" : "R2 read address", 32'(src_addr), 32'(n));
      end else chk("R2 read strobe off", 32'(src_rd), 0);
      if (n >= 1 && n <= 32) begin
        chk("R3 write strobe", 32'(buf_we), 1);
        chk("R3 write address", 32'(buf_waddr), 32'(n - 1));
        chk("R3 write data", buf_wdata, src_word(s, n - 1));
      end else chk("R3 write strobe off", 32'(buf_we), 0);
      chk(n == 33 && poke ? "R6 done time" : "R5 done", 32'(done), 32'(n == 33));
      chk("R5 busy", 32'(busy), 32'(n != 33));
      chk("R7 select held", 32'(src_sel), 32'(s));
      if (n == 0 && chained) chk("R9 chained start", 32'(src_rd), 1);
      if (poke && n == 10) begin start = 1'b1; sel_in = 2'(s + 1); end
      if (poke && n == 11) start = 1'b0;
      if (n == 33 && chain_next) begin start = 1'b1; sel_in = 2'(s_next); end
    end
    if (!chain_next) begin
      for (int k = 0; k < 32; k++) chk("R4 buffer word", bufm[k], src_word(s, k));
      for (int b = 0; b < 128; b++) begin
        byte_addr = 7'(b);
        #1;
        chk("R8 byte lane", 32'(byte_data), 32'(src_word(s, b / 4) >> (8 * (b % 4))) & 32'hFF);
      end
    end else begin
      for (int k = 0; k < 32; k++) chk("R4 buffer word", bufm[k], src_word(s, k));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 read strobe", 32'(src_rd), 0);
    chk("R1 write strobe", 32'(buf_we), 0);
    rst_n = 1'b1;
    copy(0, 0, 0, 0, 0);
    copy(1, 0, 1, 0, 0);
    copy(2, 0, 0, 1, 3);
    copy(3, 1, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule